// File: doc/BRIEF.md
# Multiplexed Capacitor-Voltage Frame Receiver

This block rebuilds a complete snapshot of submodule capacitor voltages from a train of fixed-size frames. Each frame is 33 words of 32 bits, one header word followed by 32 payload words, and one frame arrives per frame period. Every payload word carries two 16-bit signed samples, so a frame holds 64 module voltages. Sixteen frames, numbered 0 to 15 in their headers, together cover 1024 modules.

Before any payload word is stored, the header is checked for word count, version and frame index. The samples are written into a staging bank of a two-bank store. The staging bank becomes the visible bank only when frame 15 of an unbroken 0..15 sequence has been fully received. A bad header, a frame index out of order or a frame cut short abandons the set in progress, and readers keep seeing the last complete set. A read port returns any module's committed voltage one clock after the address is presented. Sticky flags report header faults, sequence breaks and out-of-range samples.

Top module: `capv_frame_rx`

## Requirements
- R1: After a synchronous reset, `set_valid`, `hdr_err`, `seq_err` and `range_err` are all 0.
- R2: A word with `in_valid` and `in_sof` high is a header. Its bits 31:20 are the frame index, bits 19:8 the payload word count and bits 7:0 the version. A header is accepted only if the count equals 32 and the version equals parameter `VERSION`.
- R3: Payload word w (0..31) of frame f stores bits 15:0 as module 64·f+2·w and bits 31:16 as module 64·f+2·w+1. `rd_data` shows the committed value of module `rd_addr` one clock after `rd_addr` is sampled.
- R4: `set_valid` is high for exactly one cycle, the cycle after the last payload word of frame 15 of an in-order set is taken. The new set is readable from that cycle on.
- R5: A header failing the count or version test sets the sticky `hdr_err`, drops that frame's payload and abandons the set in progress, without raising `seq_err`.
- R6: A valid header whose index is not the expected one sets the sticky `seq_err` and abandons the set in progress. If that index is 0, the frame starts a new set; otherwise the frame is dropped.
- R7: A header arriving before the current frame's 32nd payload word sets `seq_err` and abandons the set. The new header is then judged as if index 0 were expected.
- R8: An accepted sample below −10000 or above +10000 sets the sticky `range_err` and is still stored unchanged. The values ±10000 themselves do not set it.
- R9: Samples written during an abandoned set never become visible. Reads return the last committed set until another set completes.
- R10: Cycles with `in_valid` low are ignored, so gaps inside a frame are allowed. Words without `in_sof` that follow a completed frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word qualifier |
| in_sof | input | 1 | Marks the header word of a frame |
| in_data | input | 32 | Input word |
| rd_addr | input | 10 | Module number to read |
| rd_data | output | 16 | Committed sample of the addressed module, signed |
| set_valid | output | 1 | One-cycle strobe: a full set was committed |
| hdr_err | output | 1 | Sticky: a header failed the count or version test |
| seq_err | output | 1 | Sticky: frame order broken or frame truncated |
| range_err | output | 1 | Sticky: a stored sample exceeded ±10000 |

## Verification
Bank selection or the expected-index counter can go wrong without any flag showing it. Such a fault appears at the read port as stale or foreign samples on the first read after a commit or an abandoned set, or as a `set_valid` pulse arriving one set early or never. The bench reads module values on both sides of every abandon and commit, so a wrong staging bank or index becomes visible within one read latency. Misplaced lanes or word offsets show up as wrong values at modules 0, 1, 63, 64 and 1023.

// File: rtl/capv_pkg.sv
package capv_pkg;
  typedef struct packed {
    logic [11:0] idx;
    logic [11:0] cnt;
    logic [7:0]  ver;
  } capv_hdr_t;

  typedef enum logic [1:0] {ST_IDLE, ST_PAY, ST_DROP} capv_st_e;
endpackage

// File: rtl/capv_hdr_chk.sv
module capv_hdr_chk
  import capv_pkg::*;
#(
  parameter int PAYLOAD_WORDS = 32,
  parameter logic [7:0] VERSION = 8'h01
) (
  input  logic [31:0] word,
  output logic        fmt_ok,
  output logic [11:0] idx
);
  capv_hdr_t hdr;
  always_comb begin
    hdr    = capv_hdr_t'(word);
    idx    = hdr.idx;
    fmt_ok = (hdr.cnt == 12'(PAYLOAD_WORDS)) && (hdr.ver == VERSION);
  end
endmodule

// File: rtl/capv_range_chk.sv
module capv_range_chk #(
  parameter int DW    = 16,
  parameter int LIMIT = 10000
) (
  input  logic [DW-1:0] sample,
  output logic          bad
);
  always_comb begin
    bad = ($signed(sample) > $signed(LIMIT)) || ($signed(sample) < -$signed(LIMIT));
  end
endmodule

// File: rtl/capv_ram.sv
module capv_ram #(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [2**AW];
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/capv_frame_rx.sv
module capv_frame_rx
  import capv_pkg::*;
#(
  parameter int WORD_W        = 32,
  parameter int SAMP_W        = 16,
  parameter int PAYLOAD_WORDS = 32,
  parameter int FRAMES        = 16,
  parameter int LIMIT         = 10000,
  parameter logic [7:0] VERSION = 8'h01,
  localparam int LANES  = WORD_W / SAMP_W,
  localparam int N_MOD  = PAYLOAD_WORDS * LANES * FRAMES,
  localparam int MOD_W  = $clog2(N_MOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_sof,
  input  logic [WORD_W-1:0] in_data,
  input  logic [MOD_W-1:0]  rd_addr,
  output logic [SAMP_W-1:0] rd_data,
  output logic              set_valid,
  output logic              hdr_err,
  output logic              seq_err,
  output logic              range_err
);
  localparam int LANE_W = $clog2(LANES);
  localparam int WIDX_W = $clog2(PAYLOAD_WORDS);
  localparam int FIDX_W = $clog2(FRAMES);
  localparam int RAM_AW = 1 + FIDX_W + WIDX_W;

  capv_st_e          state;
  logic [FIDX_W-1:0] exp_f, cur_f;
  logic [WIDX_W-1:0] wcnt;
  logic              active;
  logic              fmt_ok;
  logic [11:0]       hdr_idx;
  logic [LANES-1:0]  lane_bad;
  logic [SAMP_W-1:0] lane_q [LANES];
  logic [LANE_W-1:0] rd_sel;

  logic hdr_strobe, pay_strobe, truncated, idx_match, idx_zero;
  logic [FIDX_W-1:0] base_exp;

  capv_hdr_chk #(.PAYLOAD_WORDS(PAYLOAD_WORDS), .VERSION(VERSION)) u_hdr (
    .word(in_data), .fmt_ok(fmt_ok), .idx(hdr_idx)
  );

  always_comb begin
    hdr_strobe = in_valid && in_sof;
    pay_strobe = in_valid && !in_sof && (state == ST_PAY);
    truncated  = hdr_strobe && (state == ST_PAY);
    base_exp   = truncated ? '0 : exp_f;
    idx_match  = (hdr_idx == 12'(base_exp));
    idx_zero   = (hdr_idx == 12'd0);
  end

  // Sample lanes: range check and one RAM per lane, both banks in one RAM
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SAMP_W-1:0] wsamp;
    assign wsamp = in_data[l*SAMP_W +: SAMP_W];
    capv_range_chk #(.DW(SAMP_W), .LIMIT(LIMIT)) u_rng (
      .sample(wsamp), .bad(lane_bad[l])
    );
    capv_ram #(.AW(RAM_AW), .DW(SAMP_W)) u_ram (
      .clk(clk), .we(pay_strobe),
      .waddr({~active, cur_f, wcnt}), .wdata(wsamp),
      .raddr({active, rd_addr[MOD_W-1:LANE_W]}), .rdata(lane_q[l])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel <= '0;
    else     rd_sel <= rd_addr[LANE_W-1:0];
  end
  assign rd_data = lane_q[rd_sel];

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      exp_f     <= '0;
      cur_f     <= '0;
      wcnt      <= '0;
      active    <= 1'b0;
      set_valid <= 1'b0;
      hdr_err   <= 1'b0;
      seq_err   <= 1'b0;
      range_err <= 1'b0;
    end else begin
      set_valid <= 1'b0;
      if (hdr_strobe) begin
        seq_err <= seq_err | truncated | (fmt_ok & !idx_match);
        wcnt    <= '0;
        if (!fmt_ok) begin
          hdr_err <= 1'b1;
          exp_f   <= '0;
          state   <= ST_DROP;
        end else if (idx_match || idx_zero) begin
          state <= ST_PAY;
          cur_f <= idx_match ? base_exp : '0;
          if (!idx_match || truncated) exp_f <= '0;
        end else begin
          exp_f <= '0;
          state <= ST_DROP;
        end
      end else if (pay_strobe) begin
        if (|lane_bad) range_err <= 1'b1;
        if (wcnt == WIDX_W'(PAYLOAD_WORDS - 1)) begin
          state <= ST_IDLE;
          if (cur_f == FIDX_W'(FRAMES - 1)) begin
            set_valid <= 1'b1;
            active    <= ~active;
            exp_f     <= '0;
          end else begin
            exp_f <= cur_f + 1'b1;
          end
        end else begin
          wcnt <= wcnt + 1'b1;
        end
      end
    end
  end

  // R4: commit strobe lasts one cycle and follows the final word of the last frame
  p_setv_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    set_valid |=> !set_valid);
  p_setv_last_r4: assert property (@(posedge clk) disable iff (rst)
    set_valid |-> ($past(cur_f) == FIDX_W'(FRAMES - 1)) && $past(in_valid) && !$past(in_sof));
  // R2: payload state is entered only from a header word
  p_pay_entry_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PAY && $past(state) != ST_PAY) |-> $past(in_valid && in_sof));
  // R5, R6, R8: error flags are sticky
  p_hdr_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    hdr_err |=> hdr_err);
  p_seq_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    seq_err |=> seq_err);
  p_range_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    range_err |=> range_err);
  // R7: a header during payload reception flags a sequence error
  p_trunc_r7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof && state == ST_PAY) |=> seq_err);
endmodule

// File: tb/sim_capv_frame_rx.sv
module sim_capv_frame_rx;
  localparam int CLK_P = 10;
  localparam logic [7:0] VER = 8'h01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [31:0] in_data = '0;
  logic [9:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        set_valid, hdr_err, seq_err, range_err;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;
  int ovr_m = -1;
  int ovr_v = 0;

  int    exp_q[$];
  int    m_q[$];
  string tag_q[$];
  logic  rd_req = 1'b0;
  logic  req_d = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  capv_frame_rx u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .set_valid(set_valid),
    .hdr_err(hdr_err), .seq_err(seq_err), .range_err(range_err)
  );

  task automatic check(bit ok, string tag, int act, int expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  function automatic int sval(int seed, int m);
    if (m == ovr_m) return ovr_v;
    if (m == 5) return 10000;
    if (m == 6) return -10000;
    return ((m * 7 + seed * 131) % 20001) - 10000;
  endfunction

  // Monitor: compare registered read data against the scoreboard queue
  always @(posedge clk) req_d <= rd_req;
  always @(negedge clk) begin
    if (req_d && exp_q.size() > 0) begin
      int e, m;
      string t;
      e = exp_q.pop_front();
      m = m_q.pop_front();
      t = tag_q.pop_front();
      check($signed(rd_data) == e, $sformatf("%s module %0d", t, m), $signed(rd_data), e);
    end
  end

  task automatic rd(int m, int expv, string tag);
    @(negedge clk);
    rd_addr = 10'(m);
    rd_req  = 1'b1;
    exp_q.push_back(expv);
    m_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic rd_flush();
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_set(int seed, string tag);
    rd(0, sval(seed, 0), tag);
    rd(1, sval(seed, 1), tag);
    rd(5, sval(seed, 5), tag);
    rd(6, sval(seed, 6), tag);
    rd(63, sval(seed, 63), tag);
    rd(64, sval(seed, 64), tag);
    rd(200, sval(seed, 200), tag);
    rd(517, sval(seed, 517), tag);
    rd(1023, sval(seed, 1023), tag);
    rd_flush();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_sof = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic send_frame(int idx, int cnt, int ver, int seed, int nw, int gap, int extra);
    @(negedge clk);
    in_valid = 1'b1;
    in_sof   = 1'b1;
    in_data  = {12'(idx), 12'(cnt), 8'(ver)};
    for (int w = 0; w < nw; w++) begin
      if (gap != 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_sof   = 1'b0;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_data  = {16'(sval(seed, 64*idx + 2*w + 1)), 16'(sval(seed, 64*idx + 2*w))};
    end
    for (int x = 0; x < extra; x++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = 1'b0;
      in_data  = 32'hDEAD_BEEF;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic send_set(int seed, int first, string tag);
    for (int f = first; f < 16; f++) begin
      send_frame(f, 32, VER, seed, 32, (f == 2) ? 1 : 0, (f == 3) ? 2 : 0);
      if (f == 14) check(set_valid == 1'b0, {tag, " R4 no strobe before frame 15"}, set_valid, 0);
    end
    check(set_valid == 1'b1, {tag, " R4 strobe after last word"}, set_valid, 1);
    @(negedge clk);
    check(set_valid == 1'b0, {tag, " R4 strobe one cycle"}, set_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    do_reset();
    check(set_valid == 0, "R1 set_valid", set_valid, 0);
    check(hdr_err == 0, "R1 hdr_err", hdr_err, 0);
    check(seq_err == 0, "R1 seq_err", seq_err, 0);
    check(range_err == 0, "R1 range_err", range_err, 0);

    // R2/R3/R10: clean set with gaps and trailing extra words
    send_set(1, 0, "A");
    rd_set(1, "R3 R10 set A");
    check(hdr_err == 0, "R2 good headers accepted", hdr_err, 0);
    check(seq_err == 0, "R10 extra words ignored", seq_err, 0);
    check(range_err == 0, "R8 boundary values not flagged", range_err, 0);

    // R5: bad word count abandons set, committed data stays
    for (int f = 0; f < 6; f++) send_frame(f, 32, VER, 2, 32, 0, 0);
    send_frame(6, 31, VER, 2, 32, 0, 0);
    check(hdr_err == 1, "R5 hdr_err on bad count", hdr_err, 1);
    check(seq_err == 0, "R5 no seq_err on bad header", seq_err, 0);
    rd_set(1, "R5 R9 after header fault");
    // R6: continuing at index 7 is out of order
    for (int f = 7; f < 16; f++) send_frame(f, 32, VER, 2, 32, 0, 0);
    check(seq_err == 1, "R6 seq_err on out-of-order", seq_err, 1);
    check(set_valid == 0, "R6 no commit of broken set", set_valid, 0);
    rd_set(1, "R6 R9 after broken set");
    // R6: restart at index 0
    send_set(3, 0, "B");
    rd_set(3, "R6 restart commit");

    // R2: wrong version rejected
    do_reset();
    send_frame(0, 32, 8'h7E, 4, 32, 0, 0);
    check(hdr_err == 1, "R2 wrong version rejected", hdr_err, 1);
    send_set(4, 0, "C");
    rd_set(4, "R3 set C");

    // R7: truncated frame
    for (int f = 0; f < 4; f++) send_frame(f, 32, VER, 5, 32, 0, 0);
    send_frame(4, 32, VER, 5, 10, 0, 0);
    check(seq_err == 0, "R7 no error before next header", seq_err, 0);
    send_frame(0, 32, VER, 5, 32, 0, 0);
    check(seq_err == 1, "R7 seq_err on truncation", seq_err, 1);
    rd_set(4, "R7 R9 old set visible");
    send_set(5, 1, "D");
    rd_set(5, "R7 new set from index 0");

    // R8: out-of-range sample stored unchanged
    check(range_err == 0, "R8 flag clear before", range_err, 0);
    ovr_m = 300;
    ovr_v = 12000;
    send_set(6, 0, "E");
    check(range_err == 1, "R8 range_err set", range_err, 1);
    rd(300, 12000, "R8 stored unchanged");
    rd_set(6, "R8 set E");
    ovr_m = 301;
    ovr_v = -12001;
    send_set(7, 0, "F");
    rd(301, -12001, "R8 negative stored");
    rd_flush();
    check(range_err == 1, "R8 sticky", range_err, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule